// File: doc/BRIEF.md
# Array Sum Coprocessor

This block is a coprocessor that adds up a run of 32-bit words held in memory. A host processor talks to it through a small indexed register file, using a valid/ready request channel and a valid/ready response channel. The block fetches the array on its own through a second pair of valid/ready channels that carry word read requests and their responses.

To use it, the host writes the array's start byte address into register 1 and the number of words into register 2. A write to register 0 starts the run. The host then reads register 0. That read is held off until the run is over, and it returns the 32-bit wrapped total. Inside, a three-state controller waits for configuration, issues a single memory read, then waits for that word and adds it. It repeats until the count is used up. Only one word is ever outstanding, so each element costs at least two cycles.

Top module: `accum_cop`

## Requirements
- R1: After a synchronous reset, `hreq_rdy` is 1, `hrsp_val` is 0 and `mreq_val` is 0.
- R2: A host write (`hreq_wr`=1) to index 1 sets the base byte address, and a write to index 2 sets the element count. A read (`hreq_wr`=0) of either index returns the stored value. Every write response carries data 0.
- R3: A write to index 0 clears the running sum and starts a run. Until the run ends, `hreq_rdy` stays 0, so a following read of index 0 is stalled.
- R4: A run with count N issues exactly N memory reads. Their addresses are base, base+4, base+8 and so on, in that order.
- R5: At most one memory read is outstanding. After a read request is accepted, no new request is raised until its response has been taken.
- R6: After a run, a read of index 0 returns the sum, modulo 2^32, of the N words returned by memory.
- R7: A run started with count 0 issues no memory reads, and a later read of index 0 returns 0.
- R8: Each accepted host request yields exactly one response, in order. While `hrsp_rdy` is 0, `hrsp_val` and `hrsp_data` hold steady.
- R9: Writes to indexes 3 to 31 change no state. Reads of those indexes return 0.
- R10: A raised memory request keeps `mreq_val` high and `mreq_addr` unchanged until `mreq_rdy` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hreq_val | input | 1 | Host request valid |
| hreq_rdy | output | 1 | Block can take a host request |
| hreq_wr | input | 1 | 1 = write, 0 = read |
| hreq_idx | input | 5 | Register index |
| hreq_data | input | 32 | Write data |
| hrsp_val | output | 1 | Host response valid |
| hrsp_rdy | input | 1 | Host can take the response |
| hrsp_wr | output | 1 | Response belongs to a write |
| hrsp_data | output | 32 | Read data (0 for writes) |
| mreq_val | output | 1 | Memory read request valid |
| mreq_rdy | input | 1 | Memory accepts the request |
| mreq_addr | output | 32 | Byte address of the word |
| mrsp_val | input | 1 | Memory response valid |
| mrsp_rdy | output | 1 | Block takes the memory response |
| mrsp_data | input | 32 | Returned word |

## Verification
The hardest case to reach from the ports is a host read of index 0 that arrives while a run is still going. On top of that, the memory stalls its request acceptance and its response at the same time as the host is holding back its response channel. The bench sends the read straight after the go write, so it reaches the block while reads are outstanding. It gives the memory model a variable response latency and gives both memory acceptance and host response readiness cycle-dependent gaps. Together these make the stall paths and the hold-stable rules come into play on every element. Large word values force the sum to wrap.

// File: rtl/accum_pkg.sv
package accum_pkg;
  typedef enum logic [1:0] {
    ST_CFG  = 2'd0,
    ST_RD   = 2'd1,
    ST_CALC = 2'd2
  } accum_state_e;

  localparam int unsigned IDX_GO    = 0;
  localparam int unsigned IDX_BASE  = 1;
  localparam int unsigned IDX_COUNT = 2;
endpackage

// File: rtl/accum_hostif.sv
module accum_hostif #(
  parameter int DW   = 32,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic            hreq_val,
  output logic            hreq_rdy,
  input  logic            hreq_wr,
  input  logic [IDXW-1:0] hreq_idx,
  input  logic [DW-1:0]   hreq_data,
  output logic            hrsp_val,
  input  logic            hrsp_rdy,
  output logic            hrsp_wr,
  output logic [DW-1:0]   hrsp_data,
  input  logic [DW-1:0]   sum_val,
  input  logic [DW-1:0]   base_val,
  input  logic [DW-1:0]   count_val,
  output logic            wr_base,
  output logic            wr_count,
  output logic            go
);
  import accum_pkg::*;

  logic          rsp_val_q;
  logic          rsp_wr_q;
  logic [DW-1:0] rsp_data_q;
  logic          take;
  logic [DW-1:0] rd_mux;

  assign hreq_rdy = !busy && !rsp_val_q;
  assign take     = hreq_val && hreq_rdy;
  assign wr_base  = take && hreq_wr && (hreq_idx == IDXW'(IDX_BASE));
  assign wr_count = take && hreq_wr && (hreq_idx == IDXW'(IDX_COUNT));
  assign go       = take && hreq_wr && (hreq_idx == IDXW'(IDX_GO));

  always_comb begin
    case (hreq_idx)
      IDXW'(IDX_GO):    rd_mux = sum_val;
      IDXW'(IDX_BASE):  rd_mux = base_val;
      IDXW'(IDX_COUNT): rd_mux = count_val;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_val_q  <= 1'b0;
      rsp_wr_q   <= 1'b0;
      rsp_data_q <= '0;
    end else if (take) begin
      rsp_val_q  <= 1'b1;
      rsp_wr_q   <= hreq_wr;
      rsp_data_q <= hreq_wr ? '0 : rd_mux;
    end else if (rsp_val_q && hrsp_rdy) begin
      rsp_val_q  <= 1'b0;
    end
  end

  assign hrsp_val  = rsp_val_q;
  assign hrsp_wr   = rsp_wr_q;
  assign hrsp_data = rsp_data_q;

  // R8: a response under backpressure stays put
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (hrsp_val && !hrsp_rdy) |=> (hrsp_val && $stable(hrsp_data)));

  // R3: no host request is taken while a run is in progress
  assert_busy_stall_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> !hreq_rdy);
endmodule

// File: rtl/accum_fsm.sv
module accum_fsm (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic cnt_zero,
  input  logic last,
  input  logic mreq_rdy,
  input  logic mrsp_val,
  output logic mreq_val,
  output logic mrsp_rdy,
  output logic step,
  output logic busy
);
  import accum_pkg::*;

  accum_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_CFG:  if (go && !cnt_zero) st_d = ST_RD;
      ST_RD:   if (mreq_rdy) st_d = ST_CALC;
      ST_CALC: if (mrsp_val) st_d = last ? ST_CFG : ST_RD;
      default: st_d = ST_CFG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_CFG;
    else     st_q <= st_d;
  end

  assign mreq_val = (st_q == ST_RD);
  assign mrsp_rdy = (st_q == ST_CALC);
  assign step     = (st_q == ST_CALC) && mrsp_val;
  assign busy     = (st_q != ST_CFG);

  // R10: a raised request stays raised until accepted
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mreq_val && !mreq_rdy) |=> mreq_val);

  // R5: one read in flight; no new request right after acceptance
  assert_one_flight_R5: assert property (@(posedge clk) disable iff (rst)
    (mreq_val && mreq_rdy) |=> !mreq_val);

  // R7: a go with an empty count leaves the block idle
  assert_zero_count_R7: assert property (@(posedge clk) disable iff (rst)
    (go && cnt_zero) |=> (!busy && !mreq_val));
endmodule

// File: rtl/accum_dpath.sv
module accum_dpath #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_base,
  input  logic          wr_count,
  input  logic          go,
  input  logic          step,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] sum_val,
  output logic [DW-1:0] base_val,
  output logic [DW-1:0] count_val,
  output logic          cnt_zero,
  output logic          last
);
  localparam int BYTES = DW / 8;

  logic [AW-1:0] base_q, addr_q;
  logic [DW-1:0] count_q, left_q, sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_base)  base_q  <= wdata[AW-1:0];
      if (wr_count) count_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      left_q <= '0;
      sum_q  <= '0;
    end else if (go) begin
      addr_q <= base_q;
      left_q <= count_q;
      sum_q  <= '0;
    end else if (step) begin
      addr_q <= addr_q + AW'(BYTES);
      left_q <= left_q - DW'(1);
      sum_q  <= sum_q + rdata;
    end
  end

  assign addr      = addr_q;
  assign sum_val   = sum_q;
  assign base_val  = DW'(base_q);
  assign count_val = count_q;
  assign cnt_zero  = (count_q == '0);
  assign last      = (left_q == DW'(1));
endmodule

// File: rtl/accum_cop.sv
module accum_cop #(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hreq_val,
  output logic            hreq_rdy,
  input  logic            hreq_wr,
  input  logic [IDXW-1:0] hreq_idx,
  input  logic [DW-1:0]   hreq_data,
  output logic            hrsp_val,
  input  logic            hrsp_rdy,
  output logic            hrsp_wr,
  output logic [DW-1:0]   hrsp_data,
  output logic            mreq_val,
  input  logic            mreq_rdy,
  output logic [AW-1:0]   mreq_addr,
  input  logic            mrsp_val,
  output logic            mrsp_rdy,
  input  logic [DW-1:0]   mrsp_data
);
  logic          busy, wr_base, wr_count, go, step, cnt_zero, last;
  logic [DW-1:0] sum_val, base_val, count_val;

  accum_hostif #(.DW(DW), .IDXW(IDXW)) u_hostif (
    .clk(clk), .rst(rst), .busy(busy),
    .hreq_val(hreq_val), .hreq_rdy(hreq_rdy), .hreq_wr(hreq_wr),
    .hreq_idx(hreq_idx), .hreq_data(hreq_data),
    .hrsp_val(hrsp_val), .hrsp_rdy(hrsp_rdy), .hrsp_wr(hrsp_wr),
    .hrsp_data(hrsp_data),
    .sum_val(sum_val), .base_val(base_val), .count_val(count_val),
    .wr_base(wr_base), .wr_count(wr_count), .go(go)
  );

  accum_fsm u_fsm (
    .clk(clk), .rst(rst), .go(go), .cnt_zero(cnt_zero), .last(last),
    .mreq_rdy(mreq_rdy), .mrsp_val(mrsp_val),
    .mreq_val(mreq_val), .mrsp_rdy(mrsp_rdy), .step(step), .busy(busy)
  );

  accum_dpath #(.DW(DW), .AW(AW)) u_dpath (
    .clk(clk), .rst(rst), .wr_base(wr_base), .wr_count(wr_count),
    .go(go), .step(step), .wdata(hreq_data), .rdata(mrsp_data),
    .addr(mreq_addr), .sum_val(sum_val), .base_val(base_val),
    .count_val(count_val), .cnt_zero(cnt_zero), .last(last)
  );

  // R10: the request address does not move while waiting for acceptance
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mreq_val && !mreq_rdy) |=> $stable(mreq_addr));

  // R5: memory request and response phases never overlap
  assert_phase_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(mreq_val && mrsp_rdy));
endmodule

// File: tb/tb_accum_cop.sv
module tb_accum_cop;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hreq_val = 1'b0, hreq_wr = 1'b0;
  logic [4:0]  hreq_idx = '0;
  logic [31:0] hreq_data = '0;
  logic        hreq_rdy, hrsp_val, hrsp_wr;
  logic        hrsp_rdy = 1'b0;
  logic [31:0] hrsp_data;
  logic        mreq_val, mrsp_rdy;
  logic        mreq_rdy = 1'b0, mrsp_val = 1'b0;
  logic [31:0] mreq_addr;
  logic [31:0] mrsp_data = '0;

  always #10 clk = ~clk;

  accum_cop dut (
    .clk(clk), .rst(rst),
    .hreq_val(hreq_val), .hreq_rdy(hreq_rdy), .hreq_wr(hreq_wr),
    .hreq_idx(hreq_idx), .hreq_data(hreq_data),
    .hrsp_val(hrsp_val), .hrsp_rdy(hrsp_rdy), .hrsp_wr(hrsp_wr),
    .hrsp_data(hrsp_data),
    .mreq_val(mreq_val), .mreq_rdy(mreq_rdy), .mreq_addr(mreq_addr),
    .mrsp_val(mrsp_val), .mrsp_rdy(mrsp_rdy), .mrsp_data(mrsp_data)
  );

  int errors = 0, checks = 0, cyc = 0, nreads = 0;
  logic [31:0] exp_q[$];
  int          tag_q[$];
  logic [31:0] addr_q[$];

  function automatic logic [31:0] memword(input logic [31:0] a);
    return 32'hF000_0000 + (a >> 2) * 32'h0123_4567;
  endfunction

  task automatic check(input bit ok, input int tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and host response monitor, all on the falling edge
  bit          req_f = 0, rsp_f = 0, hrsp_f = 0;
  logic [31:0] req_a = '0;
  bit          pend = 0;
  int          dly = 0;
  always @(negedge clk) begin
    cyc++;
    if (rsp_f) pend = 0;
    if (req_f) begin
      nreads++;
      if (addr_q.size() == 0) check(0, 4, req_a, 32'hx);
      else begin
        logic [31:0] ea;
        ea = addr_q.pop_front();
        check(req_a == ea, 4, req_a, ea); // R4 address order
      end
      check(!pend, 5, 32'(pend), 0);       // R5 single outstanding
      pend = 1;
      dly  = cyc % 3;
      mrsp_data = memword(req_a);
    end else if (pend && dly > 0) dly--;
    mrsp_val = pend && (dly == 0);
    mreq_rdy = (cyc % 4) != 1;
    hrsp_rdy = (cyc % 5) != 2;
    if (hrsp_val && hrsp_rdy) begin
      if (exp_q.size() == 0) check(0, 8, hrsp_data, 32'hx);
      else begin
        logic [31:0] e;
        int t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(hrsp_data == e, t, hrsp_data, e);
      end
    end
    req_f = mreq_val && mreq_rdy;
    req_a = mreq_addr;
    rsp_f = mrsp_val && mrsp_rdy;
  end

  task automatic host(input bit wr, input int idx, input logic [31:0] d,
                      input logic [31:0] exp, input int tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    #1;
    hreq_val = 1; hreq_wr = wr; hreq_idx = 5'(idx); hreq_data = d;
    while (!hreq_rdy) begin @(negedge clk); #1; end
    @(negedge clk);
    #1;
    hreq_val = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // R3 R4 R6: full run, read of index 0 sent straight after go
  task automatic run(input logic [31:0] base, input int n, input int tag);
    logic [31:0] s = 0;
    for (int i = 0; i < n; i++) begin
      addr_q.push_back(base + 32'(4 * i));
      s += memword(base + 32'(4 * i));
    end
    host(1, 1, base, 0, 2);
    host(1, 2, 32'(n), 0, 2);
    nreads = 0;
    host(1, 0, 0, 0, 3);
    host(0, 0, 0, s, tag);
    drain();
    check(nreads == n, 4, 32'(nreads), 32'(n)); // R4 exact count
    check(addr_q.size() == 0, 4, 32'(addr_q.size()), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    check(hreq_rdy == 1, 1, 32'(hreq_rdy), 1);
    check(hrsp_val == 0, 1, 32'(hrsp_val), 0);
    check(mreq_val == 0, 1, 32'(mreq_val), 0);
    // R2 config registers read back
    host(1, 1, 32'h0000_0100, 0, 2);
    host(1, 2, 32'd9, 0, 2);
    host(0, 1, 0, 32'h0000_0100, 2);
    host(0, 2, 0, 32'd9, 2);
    // R9 unused indexes
    host(1, 5, 32'hDEAD_BEEF, 0, 9);
    host(0, 5, 0, 0, 9);
    host(1, 31, 32'h1234_5678, 0, 9);
    host(0, 1, 0, 32'h0000_0100, 9);
    host(0, 2, 0, 32'd9, 9);
    drain();
    run(32'h0000_0040, 4, 6);
    run(32'h0000_0200, 1, 6);
    run(32'h0000_0000, 0, 7);  // R7 empty run
    host(0, 0, 0, 0, 7);
    drain();
    run(32'h0000_0300, 13, 6); // R6 wraps modulo 2^32, sum cleared from previous run
    run(32'h0000_0010, 5, 8);  // R8 responses in order under backpressure
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule